// File: doc/BRIEF.md
# Fuse Controller Interrupt Register Set

This block keeps the interrupt state of a fuse controller and drives one level-sensitive interrupt line. Hardware raises events through single-cycle set pulses. Five event sources sit at bit positions 0 to 4: program done, program error, read done, read error and cache error. A bus slave-error source sits at bit 31. Software reaches four 32-bit registers through a plain select/write/read port: a pending register (select 0), an enable-state register (select 1), an enable-set register (select 2) and an enable-clear register (select 3). Each select stands for one word.

The enable state is read-only. Software changes it only by writing to the set register, which ORs bits in, or to the clear register, which removes bits. Both of those registers read back as zero. The interrupt line is a flop that follows the AND of the pending and enable bits. It updates on the same clock edge that updates the registers, so it changes one cycle after the event or write that causes the change.

Top module: `fuse_irq_regs`

## Requirements
- R1: After reset the pending register reads 0x00000000, the enable state reads 0x8000001F, and irq is 0.
- R2: A pulse on evt_set[k] (k = 0..4) sets pending bit k, and a pulse on slverr_set sets pending bit 31. The bits become visible one clock later.
- R3: A write to select 0 clears each implemented pending bit that is written as 1. Bits written as 0 keep their value.
- R4: If a set pulse and a write-one-to-clear hit the same pending bit in the same cycle, the bit ends up set.
- R5: A write to select 1 does not change the enable state.
- R6: A write to select 2 ORs the written value (implemented bits only) into the enable state.
- R7: A write to select 3 clears from the enable state every bit that is written as 1.
- R8: Reads at select 2 and select 3 always return 0x00000000.
- R9: Bits 30 to 5 always read 0 at every select, and writes to them have no effect.
- R10: irq is 1 exactly when some bit of (pending AND enable state) is 1. It changes on the clock edge that updates the registers, which is one cycle after the causing pulse or write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_set | input | 5 | Set pulses for the five event sources (bits 0..4) |
| slverr_set | input | 1 | Set pulse for the slave-error source (bit 31) |
| reg_sel | input | 2 | Register select: 0 pending, 1 enable state, 2 enable set, 3 enable clear |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| irq | output | 1 | Registered level interrupt |

## Verification
Two functions can act on the same pending bit in one cycle: a hardware set pulse and a software write-one-to-clear. The bench drives both together on bit 2 while that bit is already pending, and expects the bit to stay set and irq to stay high. It also pairs an event pulse on bit 1 with an enable-clear write of bit 1 in the same cycle. There it expects the bit to become pending while irq stays low, which shows that the line is computed from the updated values of both registers.

// File: rtl/fuse_irq_pkg.sv
package fuse_irq_pkg;
  typedef enum logic [1:0] {
    SEL_PEND = 2'd0,
    SEL_ENST = 2'd1,
    SEL_ENSET = 2'd2,
    SEL_ENCLR = 2'd3
  } sel_e;

  // Implemented-bit map: low event field plus the slave-error position.
  function automatic logic [31:0] impl_map(input int evt_n, input int slv_pos);
    logic [31:0] m;
    m = '0;
    for (int b = 0; b < 32; b++) begin
      if (b < evt_n || b == slv_pos) m[b] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/fuse_irq_status.sv
module fuse_irq_status #(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] IMPL = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] set_vec,
  input  logic [DATA_W-1:0] clr_vec,
  output logic [DATA_W-1:0] pend_q,
  output logic [DATA_W-1:0] pend_d
);
  // A set pulse wins over a clear of the same bit.
  always_comb pend_d = IMPL & (set_vec | (pend_q & ~clr_vec));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(set_vec & IMPL)) |=> ((pend_q & $past(set_vec & IMPL)) == $past(set_vec & IMPL)));

  assert_w1c_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_vec & ~set_vec & IMPL)) |=> ((pend_q & $past(clr_vec & ~set_vec & IMPL)) == '0));
endmodule

// File: rtl/fuse_irq_mask.sv
module fuse_irq_mask #(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] IMPL = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_wr,
  input  logic              dis_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] mask_q,
  output logic [DATA_W-1:0] mask_d
);
  always_comb begin
    mask_d = mask_q;
    if (en_wr)       mask_d = mask_q | (wdata & IMPL);
    else if (dis_wr) mask_d = mask_q & ~wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= IMPL;
    else        mask_q <= mask_d;
  end

  assert_enable_or_R6: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr |=> ((mask_q & $past(wdata & IMPL)) == $past(wdata & IMPL)));

  assert_disable_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dis_wr |=> ((mask_q & $past(wdata)) == '0));

  assert_mask_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_wr && !dis_wr) |=> $stable(mask_q));
endmodule

// File: rtl/fuse_irq_line.sv
module fuse_irq_line #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] pend_d,
  input  logic [DATA_W-1:0] mask_d,
  output logic              irq_q
);
  // The line uses the next-state values, so it settles on the same edge as the registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |(pend_d & mask_d);
  end
endmodule

// File: rtl/fuse_irq_regs.sv
module fuse_irq_regs
  import fuse_irq_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int EVT_N   = 5,
  parameter int SLV_POS = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [EVT_N-1:0]  evt_set,
  input  logic              slverr_set,
  input  logic [1:0]        reg_sel,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  localparam logic [DATA_W-1:0] IMPL = DATA_W'(impl_map(EVT_N, SLV_POS));

  sel_e sel;
  logic [DATA_W-1:0] set_vec, clr_vec;
  logic [DATA_W-1:0] pend_q, pend_d, mask_q, mask_d;
  logic en_wr, dis_wr;

  assign sel     = sel_e'(reg_sel);
  assign set_vec = DATA_W'(evt_set) | (DATA_W'(slverr_set) << SLV_POS);
  assign clr_vec = (reg_wr && sel == SEL_PEND) ? reg_wdata : '0;
  assign en_wr   = reg_wr && sel == SEL_ENSET;
  assign dis_wr  = reg_wr && sel == SEL_ENCLR;

  fuse_irq_status #(.DATA_W(DATA_W), .IMPL(IMPL)) u_pend (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec),
    .pend_q(pend_q), .pend_d(pend_d));

  fuse_irq_mask #(.DATA_W(DATA_W), .IMPL(IMPL)) u_mask (
    .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .dis_wr(dis_wr), .wdata(reg_wdata),
    .mask_q(mask_q), .mask_d(mask_d));

  fuse_irq_line #(.DATA_W(DATA_W)) u_line (
    .clk(clk), .rst_n(rst_n), .pend_d(pend_d), .mask_d(mask_d), .irq_q(irq));

  always_comb begin
    case (sel)
      SEL_PEND: reg_rdata = pend_q;
      SEL_ENST: reg_rdata = mask_q;
      default:  reg_rdata = '0;
    endcase
  end

  assert_irq_tracks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq == |(pend_q & mask_q));

  assert_ctl_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_ENSET || sel == SEL_ENCLR) |-> reg_rdata == '0);

  assert_rsvd_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata & ~IMPL) == '0);
endmodule

// File: tb/fuse_irq_regs_test.sv
`timescale 1ns/1ps
module fuse_irq_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  evt_set = '0;
  logic        slverr_set = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  fuse_irq_regs uut (
    .clk(clk), .rst_n(rst_n), .evt_set(evt_set), .slverr_set(slverr_set),
    .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq));

  typedef struct packed {
    logic [1:0]  sel;
    logic        we;
    logic [31:0] wd;
    logic [4:0]  ev;
    logic        sv;
    logic [31:0] exp_pend;
    logic [31:0] exp_mask;
    logic        exp_irq;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b0, 32'h0,        5'b00001, 1'b0, 32'h00000001, 32'h8000001F, 1'b1}, // R2
    '{2'd0, 1'b1, 32'h1,        5'b00000, 1'b0, 32'h00000000, 32'h8000001F, 1'b0}, // R3
    '{2'd0, 1'b0, 32'h0,        5'b10100, 1'b1, 32'h80000014, 32'h8000001F, 1'b1}, // R2
    '{2'd3, 1'b1, 32'hFFFFFFFF, 5'b00000, 1'b0, 32'h80000014, 32'h00000000, 1'b0}, // R7
    '{2'd2, 1'b1, 32'h00000004, 5'b00000, 1'b0, 32'h80000014, 32'h00000004, 1'b1}, // R6
    '{2'd1, 1'b1, 32'hFFFFFFFF, 5'b00000, 1'b0, 32'h80000014, 32'h00000004, 1'b1}, // R5
    '{2'd0, 1'b1, 32'h00000004, 5'b00100, 1'b0, 32'h80000014, 32'h00000004, 1'b1}, // R4
    '{2'd0, 1'b1, 32'hFFFFFFFF, 5'b00000, 1'b0, 32'h00000000, 32'h00000004, 1'b0}, // R3
    '{2'd2, 1'b1, 32'hFFFFFFFF, 5'b00000, 1'b0, 32'h00000000, 32'h8000001F, 1'b0}, // R9
    '{2'd3, 1'b1, 32'h00000002, 5'b00010, 1'b0, 32'h00000002, 32'h8000001D, 1'b0}, // R10
    '{2'd0, 1'b1, 32'h7FFFFFE0, 5'b00000, 1'b0, 32'h00000002, 32'h8000001D, 1'b0}, // R9
    '{2'd2, 1'b1, 32'h00000002, 5'b00000, 1'b0, 32'h00000002, 32'h8000001F, 1'b1}  // R10
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] s, output logic [31:0] v);
    reg_sel = s;
    #0.3;
    v = reg_rdata;
  endtask

  task automatic step(input logic [1:0] s, input logic we, input logic [31:0] wd,
                      input logic [4:0] ev, input logic sv);
    @(negedge clk);
    reg_sel = s; reg_wr = we; reg_wdata = wd; evt_set = ev; slverr_set = sv;
    @(posedge clk);
    #0.5;
    reg_wr = 1'b0; reg_wdata = '0; evt_set = '0; slverr_set = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(2'd0, v); chk("R1 pending reset", v, 32'h0);
    rd(2'd1, v); chk("R1 enable reset", v, 32'h8000001F);
    chk("R1 irq reset", {31'b0, irq}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      step(VECS[i].sel, VECS[i].we, VECS[i].wd, VECS[i].ev, VECS[i].sv);
      rd(2'd0, v); chk($sformatf("R3/R4 vec%0d pending", i), v, VECS[i].exp_pend);
      rd(2'd1, v); chk($sformatf("R5/R6/R7 vec%0d enable", i), v, VECS[i].exp_mask);
      chk($sformatf("R10 vec%0d irq", i), {31'b0, irq}, {31'b0, VECS[i].exp_irq});
    end

    // R8: set and clear registers read zero while the enable state is nonzero
    rd(2'd2, v); chk("R8 enable-set reads 0", v, 32'h0);
    rd(2'd3, v); chk("R8 enable-clear reads 0", v, 32'h0);

    // R10 timing: the line stays put until the edge, then rises
    step(2'd0, 1'b1, 32'hFFFFFFFF, 5'b0, 1'b0);
    chk("R10 irq low after clear", {31'b0, irq}, 32'h0);
    @(negedge clk);
    slverr_set = 1'b1;
    #0.5;
    chk("R10 irq not yet high", {31'b0, irq}, 32'h0);
    @(posedge clk);
    #0.5;
    slverr_set = 1'b0;
    chk("R10 irq high one cycle later", {31'b0, irq}, 32'h1);
    rd(2'd0, v); chk("R2 slave-error pending bit 31", v, 32'h80000000);

    // R9: reserved bits reads at the pending register after writing all ones to them
    step(2'd0, 1'b1, 32'h7FFFFFE0, 5'b11111, 1'b0);
    rd(2'd0, v); chk("R9 reserved bits stay 0", v, 32'h8000001F);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule